// File: doc/BRIEF.md
# Masked Burst Address Counter

This block generates the address for one port of a memory. A start address is loaded from the external address bus. After that the block steps the address by one on each increment request, or holds it while no request is present. A mask register picks which address bits count. Bits whose mask bit is 0 keep the value they had at load time, so the mask sets the size and position of the window the burst wraps within. When the counting bits roll over from all ones to all zeros, an active-low interrupt flag drops and stays low. A retransmit request restarts the burst from the saved start address. The counter or the mask can be copied onto a readback bus so the host can inspect them.

A small state machine tracks the burst. The states are ST_IDLE (after reset or a counter clear, with no start address loaded), ST_RUN (a start address is loaded and the flag is clear) and ST_WRAP (the counter has wrapped and the flag is set). The named transitions are: T_CLEAR (any state to ST_IDLE on a counter clear), T_ARM (any state to ST_RUN on an address load or a retransmit), T_WRAP (ST_IDLE or ST_RUN to ST_WRAP on an increment that wraps) and T_STAY (every other cycle). An asynchronous master reset forces ST_IDLE at any time.

Top module: `burst_addr_counter`

## Requirements
- R1: While `mrst_n` is low the block is reset asynchronously: `mem_addr` is 0, the mask is all ones, the saved start address is 0, `int_n` is 1 and `rb_valid` is 0.
- R2: An address load (`ld_addr`) sets `mem_addr` and the saved start address to `addr_in` on the next edge and sets `int_n` to 1.
- R3: An increment (`inc`) adds one to the bits whose mask bit is 1, treated as one binary number with the masked-off bits skipped, and leaves every bit whose mask bit is 0 unchanged.
- R4: An increment taken while all bits whose mask bit is 1 are 1 clears those bits and drives `int_n` to 0 on the same edge. With a mask of all zeros every increment counts as a wrap and leaves `mem_addr` unchanged.
- R5: Once low, `int_n` stays low through increments, mask loads, reads and idle cycles. Only an address load, a retransmit, a counter clear or master reset returns it to 1.
- R6: A mask load (`ld_mask`) copies `addr_in` into the mask register and leaves `mem_addr` and `int_n` unchanged.
- R7: A retransmit (`retx`) sets `mem_addr` to the start address saved at the last address load and sets `int_n` to 1.
- R8: A counter clear (`clr`) sets `mem_addr` and the saved start address to 0 and sets `int_n` to 1. It keeps the mask.
- R9: When several requests are high in one cycle, exactly one is carried out. The order of precedence is `clr`, `ld_addr`, `ld_mask`, `retx`, `inc`, `rd_cnt`, `rd_mask`.
- R10: A counter read (`rd_cnt`) or a mask read (`rd_mask`) is carried out only when it wins under R9. On the next edge `rb_valid` goes to 1 and `rb_data` takes the counter value or the mask value. On any edge where no read is carried out, `rb_valid` goes to 0.
- R11: With no request high, `mem_addr`, the mask and `int_n` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| mrst_n | input | 1 | Asynchronous master reset, active low |
| clr | input | 1 | Clear counter and saved start address |
| ld_addr | input | 1 | Load start address from `addr_in` |
| ld_mask | input | 1 | Load mask from `addr_in` |
| retx | input | 1 | Restart burst at saved start address |
| inc | input | 1 | Advance counter by one |
| rd_cnt | input | 1 | Request counter readback |
| rd_mask | input | 1 | Request mask readback |
| addr_in | input | ADDR_W | External address bus |
| mem_addr | output | ADDR_W | Current counter value driving the memory |
| rb_data | output | ADDR_W | Readback value |
| rb_valid | output | 1 | Readback value present |
| int_n | output | 1 | Wrap flag, active low, sticky |

## Verification
On every cycle the assertions check that a load, a retransmit and a wrap land on the next edge, and that masked-off bits never move on an increment. They also check that the flag stays low across operations that must not clear it and that a readback only ever follows a read that won. The carry path through skipped bits under sparse masks, the exact precedence when several requests collide, and mid-burst master resets are shown by the bench's directed and random scenarios. There, a reference model computes the next counter and readback values with plain arithmetic.

// File: rtl/bac_pkg.sv
package bac_pkg;

    // operation chosen for one clock, listed in precedence order
    typedef enum logic [2:0] {
        OP_CLR  = 3'd0,
        OP_LDA  = 3'd1,
        OP_LDM  = 3'd2,
        OP_RTX  = 3'd3,
        OP_INC  = 3'd4,
        OP_RDC  = 3'd5,
        OP_RDM  = 3'd6,
        OP_HOLD = 3'd7
    } op_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_WRAP = 2'd2
    } burst_state_e;

endpackage

// File: rtl/bac_cmd_decode.sv
module bac_cmd_decode
    import bac_pkg::*;
(
    input  logic clr,
    input  logic ld_addr,
    input  logic ld_mask,
    input  logic retx,
    input  logic inc,
    input  logic rd_cnt,
    input  logic rd_mask,
    output op_e  op
);

    // fixed precedence: first request high wins
    always_comb begin
        if (clr)          op = OP_CLR;
        else if (ld_addr) op = OP_LDA;
        else if (ld_mask) op = OP_LDM;
        else if (retx)    op = OP_RTX;
        else if (inc)     op = OP_INC;
        else if (rd_cnt)  op = OP_RDC;
        else if (rd_mask) op = OP_RDM;
        else              op = OP_HOLD;
    end

endmodule

// File: rtl/bac_step.sv
module bac_step #(
    parameter int ADDR_W = 16
) (
    input  logic [ADDR_W-1:0] cur,
    input  logic [ADDR_W-1:0] mask,
    output logic [ADDR_W-1:0] nxt,
    output logic              wrap
);

    // carry ripples through the counting bits and passes straight over
    // masked-off bits, so the counting bits act as one binary number
    logic [ADDR_W:0] carry;

    assign carry[0] = 1'b1;

    for (genvar b = 0; b < ADDR_W; b++) begin : g_bit
        always_comb begin
            if (mask[b]) begin
                nxt[b]     = cur[b] ^ carry[b];
                carry[b+1] = cur[b] & carry[b];
            end else begin
                nxt[b]     = cur[b];
                carry[b+1] = carry[b];
            end
        end
    end

    assign wrap = carry[ADDR_W];

endmodule

// File: rtl/bac_readback.sv
module bac_readback
    import bac_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              mrst_n,
    input  op_e               op,
    input  logic [ADDR_W-1:0] cnt,
    input  logic [ADDR_W-1:0] mask,
    output logic [ADDR_W-1:0] rb_data,
    output logic              rb_valid
);

    always_ff @(posedge clk or negedge mrst_n) begin
        if (!mrst_n) begin
            rb_data  <= '0;
            rb_valid <= 1'b0;
        end else begin
            rb_valid <= (op == OP_RDC) || (op == OP_RDM);
            if (op == OP_RDC)      rb_data <= cnt;
            else if (op == OP_RDM) rb_data <= mask;
        end
    end

    // R10: readback is present only after a read that won precedence
    a_r10_rb_after_read: assert property (@(posedge clk) disable iff (!mrst_n)
        rb_valid |-> ($past(op) == OP_RDC) || ($past(op) == OP_RDM));

endmodule

// File: rtl/burst_addr_counter.sv
module burst_addr_counter
    import bac_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              mrst_n,
    input  logic              clr,
    input  logic              ld_addr,
    input  logic              ld_mask,
    input  logic              retx,
    input  logic              inc,
    input  logic              rd_cnt,
    input  logic              rd_mask,
    input  logic [ADDR_W-1:0] addr_in,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [ADDR_W-1:0] rb_data,
    output logic              rb_valid,
    output logic              int_n
);

    localparam logic [ADDR_W-1:0] MASK_ALL = {ADDR_W{1'b1}};

    op_e               op;
    burst_state_e      state_q, state_d;
    logic [ADDR_W-1:0] cnt_q, cnt_d;
    logic [ADDR_W-1:0] mask_q, mask_d;
    logic [ADDR_W-1:0] start_q, start_d;
    logic [ADDR_W-1:0] step_val;
    logic              step_wrap;

    bac_cmd_decode u_dec (
        .clr     (clr),
        .ld_addr (ld_addr),
        .ld_mask (ld_mask),
        .retx    (retx),
        .inc     (inc),
        .rd_cnt  (rd_cnt),
        .rd_mask (rd_mask),
        .op      (op)
    );

    bac_step #(.ADDR_W(ADDR_W)) u_step (
        .cur  (cnt_q),
        .mask (mask_q),
        .nxt  (step_val),
        .wrap (step_wrap)
    );

    bac_readback #(.ADDR_W(ADDR_W)) u_rb (
        .clk      (clk),
        .mrst_n   (mrst_n),
        .op       (op),
        .cnt      (cnt_q),
        .mask     (mask_q),
        .rb_data  (rb_data),
        .rb_valid (rb_valid)
    );

    // next-state and datapath selection
    always_comb begin
        state_d = state_q;   // T_STAY
        cnt_d   = cnt_q;
        mask_d  = mask_q;
        start_d = start_q;
        unique case (op)
            OP_CLR: begin
                cnt_d   = '0;
                start_d = '0;
                state_d = ST_IDLE;        // T_CLEAR
            end
            OP_LDA: begin
                cnt_d   = addr_in;
                start_d = addr_in;
                state_d = ST_RUN;         // T_ARM
            end
            OP_LDM: begin
                mask_d = addr_in;
            end
            OP_RTX: begin
                cnt_d   = start_q;
                state_d = ST_RUN;         // T_ARM
            end
            OP_INC: begin
                cnt_d = step_val;
                if (step_wrap) state_d = ST_WRAP;   // T_WRAP
            end
            OP_RDC, OP_RDM, OP_HOLD: begin
            end
            default: begin
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge mrst_n) begin
        if (!mrst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            mask_q  <= MASK_ALL;
            start_q <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            mask_q  <= mask_d;
            start_q <= start_d;
        end
    end

    // outputs
    always_comb begin
        mem_addr = cnt_q;
        unique case (state_q)
            ST_WRAP: int_n = 1'b0;
            ST_IDLE,
            ST_RUN:  int_n = 1'b1;
            default: int_n = 1'b1;
        endcase
    end

    // R2: load lands on next edge and clears the flag
    a_r2_load_addr: assert property (@(posedge clk) disable iff (!mrst_n)
        (op == OP_LDA) |=> (mem_addr == $past(addr_in)) && int_n);

    // R3: masked-off bits never move on an increment
    a_r3_masked_hold: assert property (@(posedge clk) disable iff (!mrst_n)
        (op == OP_INC) |=> ((mem_addr ^ $past(mem_addr)) & ~$past(mask_q)) == '0);

    // R4: a wrap from the step logic sets the flag
    a_r4_wrap_flag: assert property (@(posedge clk) disable iff (!mrst_n)
        (op == OP_INC && step_wrap) |=> !int_n);

    // R5: flag sticks across operations that do not clear it
    a_r5_flag_sticky: assert property (@(posedge clk) disable iff (!mrst_n)
        (!int_n && (op == OP_INC || op == OP_LDM || op == OP_RDC ||
                    op == OP_RDM || op == OP_HOLD)) |=> !int_n);

    // R7: retransmit returns to the saved start
    a_r7_retx: assert property (@(posedge clk) disable iff (!mrst_n)
        (op == OP_RTX) |=> (mem_addr == $past(start_q)) && int_n);

    // R6: mask load leaves the counter alone
    a_r6_mask_load: assert property (@(posedge clk) disable iff (!mrst_n)
        (op == OP_LDM) |=> $stable(mem_addr) && (mask_q == $past(addr_in)));

endmodule

// File: tb/burst_addr_counter_tb_top.sv
`timescale 1ns/1ps
module burst_addr_counter_tb_top;

    localparam int W = 16;
    localparam int WATCHDOG_NS = 400000;

    logic         clk = 1'b0;
    logic         mrst_n = 1'b0;
    logic         clr = 0, ld_addr = 0, ld_mask = 0, retx = 0, inc = 0;
    logic         rd_cnt = 0, rd_mask = 0;
    logic [W-1:0] addr_in = '0;
    logic [W-1:0] mem_addr, rb_data;
    logic         rb_valid, int_n;

    always #4 clk = ~clk;   // 125 MHz

    burst_addr_counter #(.ADDR_W(W)) dut_i (
        .clk(clk), .mrst_n(mrst_n), .clr(clr), .ld_addr(ld_addr),
        .ld_mask(ld_mask), .retx(retx), .inc(inc), .rd_cnt(rd_cnt),
        .rd_mask(rd_mask), .addr_in(addr_in), .mem_addr(mem_addr),
        .rb_data(rb_data), .rb_valid(rb_valid), .int_n(int_n)
    );

    // reference model state
    logic [W-1:0] m_cnt, m_mask, m_start, m_rbd;
    logic         m_intn, m_rbv;
    int           n_tests = 0, n_fail = 0;
    bit           done = 0;

    // increment: force skipped bits to 1 so the carry passes them
    function automatic logic [W-1:0] ref_inc(logic [W-1:0] c, logic [W-1:0] m);
        logic [W-1:0] s;
        s = (c | ~m) + 1'b1;
        return (c & ~m) | (s & m);
    endfunction

    function automatic logic ref_wrap(logic [W-1:0] c, logic [W-1:0] m);
        return (c & m) == m;
    endfunction

    task automatic model_reset();
        m_cnt = '0; m_mask = '1; m_start = '0; m_intn = 1; m_rbv = 0; m_rbd = '0;
    endtask

    task automatic model_step(output string tag);
        m_rbv = 0;
        if (clr) begin
            m_cnt = '0; m_start = '0; m_intn = 1; tag = "R8";
        end else if (ld_addr) begin
            m_cnt = addr_in; m_start = addr_in; m_intn = 1; tag = "R2";
        end else if (ld_mask) begin
            m_mask = addr_in; tag = "R6";
        end else if (retx) begin
            m_cnt = m_start; m_intn = 1; tag = "R7";
        end else if (inc) begin
            if (ref_wrap(m_cnt, m_mask)) m_intn = 0;
            m_cnt = ref_inc(m_cnt, m_mask); tag = "R3";
        end else if (rd_cnt) begin
            m_rbv = 1; m_rbd = m_cnt; tag = "R10";
        end else if (rd_mask) begin
            m_rbv = 1; m_rbd = m_mask; tag = "R10";
        end else tag = "R11";
    endtask

    task automatic check(string tag, string what, logic [W-1:0] act, logic [W-1:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic check_all(string tag);
        check(tag, "mem_addr", mem_addr, m_cnt);
        check("R4 R5", "int_n", {{(W-1){1'b0}}, int_n}, {{(W-1){1'b0}}, m_intn});
        check("R10", "rb_valid", {{(W-1){1'b0}}, rb_valid}, {{(W-1){1'b0}}, m_rbv});
        if (m_rbv) check("R10", "rb_data", rb_data, m_rbd);
    endtask

    // drive one cycle at negedge, let model follow the edge, check at next negedge
    task automatic cyc(logic c, logic la, logic lm, logic rt, logic ic,
                       logic rc, logic rm, logic [W-1:0] a);
        string tag;
        clr = c; ld_addr = la; ld_mask = lm; retx = rt; inc = ic;
        rd_cnt = rc; rd_mask = rm; addr_in = a;
        @(posedge clk);
        model_step(tag);
        @(negedge clk);
        check_all(tag);
    endtask

    task automatic idle(); cyc(0,0,0,0,0,0,0,'0); endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(WATCHDOG_NS);
        n_fail++;
        $display("FAIL watchdog expired actual=hung expected=done");
        finish_run();
    end

    initial begin
        model_reset();
        repeat (2) @(negedge clk);
        // R1: reset state
        check("R1", "mem_addr", mem_addr, '0);
        check("R1", "int_n", {{(W-1){1'b0}}, int_n}, {{(W-1){1'b0}}, 1'b1});
        check("R1", "rb_valid", {{(W-1){1'b0}}, rb_valid}, '0);
        mrst_n = 1;
        cyc(0,0,0,0,0,0,1,'0);   // R1: mask reads back all ones
        check("R1", "mask after reset", rb_data, 16'hFFFF);

        // R3 R4: 4-bit window, wrap and sticky flag
        cyc(0,0,1,0,0,0,0,16'h000F);
        cyc(0,1,0,0,0,0,0,16'hA5FD);
        repeat (4) cyc(0,0,0,0,1,0,0,'0);
        check("R4", "window wrap", mem_addr, 16'hA5F1);
        idle();
        cyc(0,0,1,0,0,0,0,16'h000F);             // R5 mask load keeps flag
        check("R5", "flag sticky", {{(W-1){1'b0}}, int_n}, '0);
        cyc(0,0,0,1,0,0,0,'0);                   // R7 retransmit
        check("R7", "retx start", mem_addr, 16'hA5FD);

        // R3: sparse mask, carry jumps skipped bits
        cyc(0,0,1,0,0,0,0,16'h8101);
        cyc(0,1,0,0,0,0,0,16'h0001);
        cyc(0,0,0,0,1,0,0,'0);
        check("R3", "sparse carry", mem_addr, 16'h0100);

        // R4: mask zero, every increment wraps without moving
        cyc(0,0,1,0,0,0,0,16'h0000);
        cyc(0,1,0,0,0,0,0,16'h1234);
        cyc(0,0,0,0,1,0,0,'0);
        check("R4", "zero mask", mem_addr, 16'h1234);

        // R9: precedence collisions
        cyc(0,1,1,1,1,1,1,16'h4444);
        check("R9", "load beats rest", mem_addr, 16'h4444);
        cyc(1,1,1,1,1,1,1,16'h5555);
        check("R9", "clear beats rest", mem_addr, 16'h0000);
        cyc(0,0,0,0,0,1,1,'0);
        check("R9", "rd_cnt beats rd_mask", rb_data, 16'h0000);
        cyc(0,0,1,1,1,1,1,16'hFFFF);             // R9 mask load wins
        cyc(0,0,0,1,1,1,1,'0);                   // R9 retransmit wins
        cyc(0,0,0,0,1,1,1,'0);                   // R9 inc wins, no read
        check("R10", "no read on inc", {{(W-1){1'b0}}, rb_valid}, '0);
        cyc(0,0,0,0,0,1,0,'0);                   // R10 counter read
        repeat (3) idle();                        // R11 hold

        // random stimulus, fixed seed
        void'($urandom(32'd7741));
        for (int i = 0; i < 3000; i++) begin
            logic [W-1:0] a;
            int sel;
            if (($urandom % 400) == 0) begin
                @(negedge clk);
                mrst_n = 0;
                #1 model_reset();
                @(negedge clk);
                check_all("R1");
                mrst_n = 1;
            end
            sel = $urandom % 4;
            a = $urandom;
            if (sel == 0) a = a & 16'h000F;
            else if (sel == 1) a = a | 16'hFFF0;
            cyc(($urandom % 40) == 0, ($urandom % 12) == 0, ($urandom % 12) == 0,
                ($urandom % 15) == 0, ($urandom % 2) == 0, ($urandom % 6) == 0,
                ($urandom % 6) == 0, a);
        end
        finish_run();
    end

endmodule